// File: doc/BRIEF.md
# Remote Reservation Status Tracker

This block keeps one reservation status bit on the processor side so that software can wait for a semaphore by polling a local bit. Without it, software would spin on reads across the bus. The bit sets when the processor sends a cache-inhibited load-reserve read into its outgoing transaction stream. The bit drops only when a clear event arrives from the memory side.

The block also holds the memory-side detector. The detector watches writes to memory and compares each write address with a 4 KiB semaphore page whose base is a parameter. A write inside that page means a semaphore has been released, and the detector emits a one-cycle release pulse. That pulse, ORed with a general system clear input, forms the clear line into the tracker.

The tracker is a two-state machine:
- `ST_FREE`: the bit reads 0.
- `ST_HELD`: the bit reads 1.

Its transitions are:
- *arm*: `ST_FREE` to `ST_HELD` on a set.
- *rearm*: `ST_HELD` to `ST_HELD` on a set, even when a clear is present.
- *release*: `ST_HELD` to `ST_FREE` on a clear with no set.
- *idle*: the state stays as it is otherwise.

Software reads the bit through a local read port, which never produces bus traffic.

Top module: `resv_watch`

## Requirements
- R1: After `rst` the status bit, the release pulse and the read data are all 0. An `rst` asserted while the bit is 1 returns it to 0.
- R2: A transaction with `txn_valid`=1, `txn_kind`=3'b001 (load-reserve read) and `txn_ci`=1 sets the status bit at the next rising edge.
- R3: Plain reads (`txn_kind`=3'b000), cacheable load-reserve reads (`txn_ci`=0), writes (`txn_kind`=3'b010) and transactions with `txn_valid`=0 leave the status bit unchanged.
- R4: `sys_clear`=1 with no set in the same cycle clears the status bit at the next rising edge.
- R5: When a set and a clear (from `sys_clear` or the release pulse) occur in the same cycle, the bit is 1 after the edge.
- R6: A memory write (`mw_valid`=1) with `mw_addr[ADDR_W-1:12]` equal to `SEM_BASE[ADDR_W-1:12]` raises `rel_pulse` for exactly the following cycle, one cycle per write. The status bit clears one edge after the pulse, unless a set coincides with it.
- R7: Memory writes outside the semaphore page (including base-1 and base+0x1000) produce no pulse and leave the status bit unchanged.
- R8: With `sw_rd_en`=1, `sw_rd_data` takes the status bit's value at the next edge. It holds its value while `sw_rd_en`=0, and reads never change the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Outgoing bus transaction present |
| txn_kind | input | 3 | Transaction kind (000 read, 001 load-reserve, 010 write, 011 conditional write) |
| txn_ci | input | 1 | Transaction is cache-inhibited |
| sys_clear | input | 1 | Synchronous active-high system clear event |
| mw_valid | input | 1 | Memory-side write observed |
| mw_addr | input | ADDR_W | Address of the observed memory write |
| sw_rd_en | input | 1 | Local software read strobe |
| sw_rd_data | output | 1 | Registered read data for software |
| resv_bit | output | 1 | Current reservation status bit |
| rel_pulse | output | 1 | One-cycle release pulse from the page detector |

## Verification
A stuck or wrongly entered state shows at `resv_bit` one edge after the set or clear that should have moved it. It shows at `sw_rd_data` one edge after the next read. A faulty page compare shows at `rel_pulse` one edge after the write, and as a missing or spurious drop of `resv_bit` one edge later. The bench therefore samples each output at the first edge where the requirements say it changes.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [2:0] {
        K_READ  = 3'b000,
        K_RESV  = 3'b001,
        K_WRITE = 3'b010,
        K_WCOND = 3'b011
    } txn_kind_e;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } resv_state_e;
endpackage

// File: rtl/resv_txn_decode.sv
module resv_txn_decode
    import resv_pkg::*;
(
    input  logic       txn_valid,
    input  logic [2:0] txn_kind,
    input  logic       txn_ci,
    output logic       set_hit
);
    // Only a cache-inhibited load-reserve read arms the reservation (R2, R3)
    always_comb begin
        set_hit = txn_valid && txn_ci && (txn_kind == 3'(K_RESV));
    end
endmodule

// File: rtl/resv_page_snoop.sv
module resv_page_snoop #(
    parameter int                ADDR_W    = 32,
    parameter int                PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] SEM_BASE  = 32'h0004_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mw_valid,
    input  logic [ADDR_W-1:0] mw_addr,
    output logic              rel_pulse
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BASE_TAG  = SEM_BASE & PAGE_MASK;

    logic page_hit;

    always_comb begin
        page_hit = mw_valid && ((mw_addr & PAGE_MASK) == BASE_TAG);
    end

    // One registered pulse per matching write (R6, R7)
    always_ff @(posedge clk) begin
        if (rst) rel_pulse <= 1'b0;
        else     rel_pulse <= page_hit;
    end
endmodule

// File: rtl/resv_state_fsm.sv
module resv_state_fsm
    import resv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_hit,
    input  logic clr_line,
    output logic resv_bit
);
    resv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (set_hit) state_d = ST_HELD;   // arm
            ST_HELD: begin
                if (set_hit)       state_d = ST_HELD;  // rearm, set beats clear (R5)
                else if (clr_line) state_d = ST_FREE;  // release (R4)
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        resv_bit = (state_q == ST_HELD);
    end
endmodule

// File: rtl/resv_watch.sv
module resv_watch #(
    parameter int                ADDR_W    = 32,
    parameter int                PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] SEM_BASE  = 32'h0004_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_valid,
    input  logic [2:0]        txn_kind,
    input  logic              txn_ci,
    input  logic              sys_clear,
    input  logic              mw_valid,
    input  logic [ADDR_W-1:0] mw_addr,
    input  logic              sw_rd_en,
    output logic              sw_rd_data,
    output logic              resv_bit,
    output logic              rel_pulse
);
    logic set_hit;
    logic clr_line;

    resv_txn_decode u_dec (
        .txn_valid (txn_valid),
        .txn_kind  (txn_kind),
        .txn_ci    (txn_ci),
        .set_hit   (set_hit)
    );

    resv_page_snoop #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .SEM_BASE  (SEM_BASE)
    ) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .mw_valid  (mw_valid),
        .mw_addr   (mw_addr),
        .rel_pulse (rel_pulse)
    );

    always_comb begin
        clr_line = sys_clear || rel_pulse;
    end

    resv_state_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .set_hit  (set_hit),
        .clr_line (clr_line),
        .resv_bit (resv_bit)
    );

    // Local read port, no bus activity involved (R8)
    always_ff @(posedge clk) begin
        if (rst)           sw_rd_data <= 1'b0;
        else if (sw_rd_en) sw_rd_data <= resv_bit;
    end
endmodule

// File: rtl/resv_watch_chk.sv
module resv_watch_chk #(
    parameter int                ADDR_W    = 32,
    parameter int                PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] SEM_BASE  = 32'h0004_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              txn_valid,
    input logic [2:0]        txn_kind,
    input logic              txn_ci,
    input logic              sys_clear,
    input logic              mw_valid,
    input logic [ADDR_W-1:0] mw_addr,
    input logic              sw_rd_en,
    input logic              sw_rd_data,
    input logic              resv_bit,
    input logic              rel_pulse
);
    logic arm;
    logic clr;
    logic in_page;

    always_comb begin
        arm     = txn_valid && txn_ci && (txn_kind == 3'b001);
        clr     = sys_clear || rel_pulse;
        in_page = mw_valid && (mw_addr[ADDR_W-1:PAGE_BITS] == SEM_BASE[ADDR_W-1:PAGE_BITS]);
    end

    p_set_r2: assert property (@(posedge clk) disable iff (rst) arm |=> resv_bit);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst) (arm && clr) |=> resv_bit);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst) (!arm && clr) |=> !resv_bit);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst) (!arm && !clr) |=> $stable(resv_bit));
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst) in_page |=> rel_pulse);
    p_no_pulse_r7: assert property (@(posedge clk) disable iff (rst) !in_page |=> !rel_pulse);
    p_read_r8: assert property (@(posedge clk) disable iff (rst) sw_rd_en |=> (sw_rd_data == $past(resv_bit)));
    p_read_hold_r8: assert property (@(posedge clk) disable iff (rst) !sw_rd_en |=> $stable(sw_rd_data));
endmodule

bind resv_watch resv_watch_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .SEM_BASE  (SEM_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txn_valid  (txn_valid),
    .txn_kind   (txn_kind),
    .txn_ci     (txn_ci),
    .sys_clear  (sys_clear),
    .mw_valid   (mw_valid),
    .mw_addr    (mw_addr),
    .sw_rd_en   (sw_rd_en),
    .sw_rd_data (sw_rd_data),
    .resv_bit   (resv_bit),
    .rel_pulse  (rel_pulse)
);

// File: tb/resv_watch_test.sv
module resv_watch_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0004_0000;
    localparam logic [31:0] HIT  = 32'h0004_0010;
    localparam logic [31:0] MISS = 32'h0005_0000;
    localparam int NV = 19;

    // {tv, kind[2:0], ci, sclr, mw, mhit, exp_bit, exp_pulse}
    localparam logic [9:0] VEC [NV] = '{
        10'b1_001_1_0_0_0_1_0, // 0  R2 set
        10'b1_000_1_0_0_0_1_0, // 1  R3 plain read
        10'b0_000_0_1_0_0_0_0, // 2  R4 sys clear
        10'b1_001_0_0_0_0_0_0, // 3  R3 cacheable reserve
        10'b1_000_1_0_0_0_0_0, // 4  R3 plain CI read
        10'b1_010_1_0_0_0_0_0, // 5  R3 write
        10'b1_001_1_0_0_0_1_0, // 6  R2 set
        10'b0_000_0_0_1_1_1_1, // 7  R6 page write -> pulse
        10'b0_000_0_0_0_0_0_0, // 8  R6 bit drops after pulse
        10'b0_000_0_0_1_0_0_0, // 9  R7 miss write
        10'b1_001_1_0_0_0_1_0, // 10 R2 set
        10'b0_000_0_0_1_0_1_0, // 11 R7 miss keeps bit
        10'b0_001_1_0_0_0_1_0, // 12 R3 txn_valid low
        10'b1_001_1_1_0_0_1_0, // 13 R5 set + sys clear
        10'b0_000_0_0_1_1_1_1, // 14 R6 pulse
        10'b1_001_1_0_0_0_1_0, // 15 R5 set beats pulse
        10'b0_000_0_0_0_0_1_0, // 16 R3 idle
        10'b0_000_0_1_0_0_0_0, // 17 R4 clear
        10'b0_000_0_1_0_0_0_0  // 18 R4 clear while free
    };
    localparam int VREQ [NV] = '{2,3,4,3,3,3,2,6,6,7,2,7,3,5,6,5,3,4,4};

    logic clk = 1'b0;
    logic rst;
    logic txn_valid, txn_ci, sys_clear, mw_valid, sw_rd_en;
    logic [2:0] txn_kind;
    logic [31:0] mw_addr;
    logic sw_rd_data, resv_bit, rel_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_watch #(.ADDR_W(32), .PAGE_BITS(12), .SEM_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_ci(txn_ci), .sys_clear(sys_clear), .mw_valid(mw_valid),
        .mw_addr(mw_addr), .sw_rd_en(sw_rd_en), .sw_rd_data(sw_rd_data),
        .resv_bit(resv_bit), .rel_pulse(rel_pulse)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_in();
        txn_valid = 0; txn_kind = 3'b000; txn_ci = 0; sys_clear = 0;
        mw_valid = 0; mw_addr = '0; sw_rd_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_set();
        idle_in(); txn_valid = 1; txn_kind = 3'b001; txn_ci = 1;
        step(); idle_in();
    endtask

    task automatic do_write(input logic [31:0] a);
        idle_in(); mw_valid = 1; mw_addr = a;
        step(); idle_in();
    endtask

    initial begin
        idle_in();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 bit", resv_bit, 1'b0);
        chk("R1 pulse", rel_pulse, 1'b0);
        chk("R1 rd", sw_rd_data, 1'b0);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            txn_valid = v[9]; txn_kind = v[8:6]; txn_ci = v[5]; sys_clear = v[4];
            mw_valid = v[3]; mw_addr = v[2] ? HIT : MISS;
            step();
            chk($sformatf("R%0d vec%0d bit", VREQ[i], i), resv_bit, v[1]);
            chk($sformatf("R%0d vec%0d pulse", VREQ[i], i), rel_pulse, v[0]);
        end
        idle_in();

        // R8 read port
        do_set();
        sw_rd_en = 1; step(); sw_rd_en = 0;
        chk("R8 read 1", sw_rd_data, 1'b1);
        chk("R8 read leaves bit", resv_bit, 1'b1);
        sys_clear = 1; step(); sys_clear = 0;
        chk("R8 hold rd_data", sw_rd_data, 1'b1);
        sw_rd_en = 1; step(); sw_rd_en = 0;
        chk("R8 read 0", sw_rd_data, 1'b0);
        for (int k = 0; k < 3; k++) begin
            sw_rd_en = 1; step();
        end
        sw_rd_en = 0;
        chk("R8 repeated reads keep bit", resv_bit, 1'b0);

        // R6 page edges and back-to-back writes
        do_set();
        do_write(BASE + 32'h0000_0FFF);
        chk("R6 top of page pulse", rel_pulse, 1'b1);
        step();
        chk("R6 bit cleared", resv_bit, 1'b0);
        do_set();
        do_write(BASE - 32'd1);
        chk("R7 base-1 no pulse", rel_pulse, 1'b0);
        do_write(BASE + 32'h0000_1000);
        chk("R7 next page no pulse", rel_pulse, 1'b0);
        chk("R7 bit kept", resv_bit, 1'b1);
        idle_in(); mw_valid = 1; mw_addr = BASE;
        step();
        chk("R6 first of two", rel_pulse, 1'b1);
        step(); idle_in();
        chk("R6 second of two", rel_pulse, 1'b1);
        step();
        chk("R6 pulse ends", rel_pulse, 1'b0);

        // R1 reset while held
        do_set();
        chk("R2 set before reset", resv_bit, 1'b1);
        rst = 1; step(); rst = 0;
        chk("R1 reset clears bit", resv_bit, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule